// File: doc/BRIEF.md
# Prescaled Dual Counter/Timer

This block holds two 8-bit down counters, each preceded by its own 6-bit prescaler. A counter counts down from an initial value that software writes. When it reaches its end of count, it raises a one-cycle request towards the interrupt controller. Each counter then either stops (single-pass) or reloads its initial value and keeps counting (auto-reload). Timer 0 always runs from the internal time base, which is the system clock divided by four.

Timer 1 has several possible sources. It can use the same internal time base. It can use rising edges of an external input as its clock. It can use the external input as a gate on the internal time base. It can use the external input as a trigger, in retriggerable or non-retriggerable form. It can also be chained to the end-of-count pulses of timer 0.

A single output pin toggles on the end of count of either timer, toggles on the internal time base, or stays low. Software controls the block through a small write port and can read both counters at any time without disturbing them.

Top module: `dual_prescaled_timer`

## Requirements
- R1: A prescaler value P written in bits [5:0] of address 2 (timer 0) or address 3 (timer 1) divides the selected source by P. The value 0 divides by 64. In auto-reload, timer 0 raises an end of count every N*P*4 clocks.
- R2: The initial count N written at address 0 (timer 0) or address 1 (timer 1) is counted down to end of count. The value 0 counts 256 steps.
- R3: With bit 6 of the prescaler register set (auto-reload), the counter reloads its initial value at end of count and keeps counting, so end-of-count pulses repeat with a fixed period.
- R4: With bit 6 clear (single-pass), the counter raises exactly one end of count. It then stops with its count reading 0 and raises no further request.
- R5: Writing address 4 with bit 0 (timer 0) or bit 2 (timer 1) set loads the initial count and prescaler and arms that timer. Bit 1 (timer 0) and bit 3 (timer 1) are held enables. While an enable is 0 the count holds its value; setting it again continues from that value.
- R6: With bit 7 of address 3 clear and mode field bits [5:4] of address 4 equal to 00, every synchronized rising edge of `ext_in` is one timer 1 prescaler tick.
- R7: In mode 01, timer 1 counts the internal time base only while the synchronized `ext_in` is high.
- R8: In mode 10 (non-retriggerable), a rising edge of `ext_in` loads and arms timer 1 when it is idle. An edge while it is running is ignored.
- R9: In mode 11 (retriggerable), every rising edge of `ext_in` reloads timer 1, including in the middle of a run.
- R10: With bit 0 of address 5 set, timer 1 takes one tick per timer 0 end of count, whatever its source and mode settings are.
- R11: Output select bits [7:6] of address 4 control `tout`. The value 00 holds `tout` low. The value 01 toggles it on each timer 0 end of count, 10 on each timer 1 end of count, and 11 on each internal time-base tick (every 4 clocks).
- R12: After reset both counts read 0 and `irq0`, `irq1` and `tout` are low. Each end of count gives a request pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | 8 | Register write data |
| ext_in | input | 1 | Asynchronous external timer input |
| count0 | output | 8 | Current timer 0 count |
| count1 | output | 8 | Current timer 1 count |
| irq0 | output | 1 | Timer 0 end-of-count request pulse |
| irq1 | output | 1 | Timer 1 end-of-count request pulse |
| tout | output | 1 | Timer output pin |

## Verification
The bench checks the zero encodings of both the count and the prescaler. A design that decodes 0 literally would fire almost at once instead of after 256 or 64 steps. It separates the two trigger flavours with a second edge in mid-run. A non-retriggerable timer that reloads on that edge, or a retriggerable one that ignores it, moves the request by twenty clocks.

The bench checks that single-pass mode gives exactly one request, which catches a counter that wraps from 0 to 255. It also checks that a cleared enable freezes the count, and that chaining makes timer 1 period exactly the product of both timers' periods.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef enum logic [1:0] {
    EXT_CLOCK     = 2'b00,
    EXT_GATE      = 2'b01,
    EXT_TRIG_ONCE = 2'b10,
    EXT_TRIG_RE   = 2'b11
  } ext_mode_e;

  typedef enum logic [1:0] {
    OUT_OFF  = 2'b00,
    OUT_T0   = 2'b01,
    OUT_T1   = 2'b10,
    OUT_TICK = 2'b11
  } out_sel_e;

  typedef enum logic [2:0] {
    REG_T0_INIT = 3'd0,
    REG_T1_INIT = 3'd1,
    REG_T0_PRE  = 3'd2,
    REG_T1_PRE  = 3'd3,
    REG_CTRL    = 3'd4,
    REG_CHAIN   = 3'd5
  } reg_addr_e;

  // Number of steps a W-bit field stands for: zero encodes 2**W.
  function automatic int unsigned span(input int unsigned v, input int unsigned w);
    return (v == 0) ? (32'd1 << w) : v;
  endfunction

endpackage

// File: rtl/dpt_input_cond.sv
module dpt_input_cond #(
  parameter int SYNC_N = 2,
  parameter int DIV_W  = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic ext_lvl_o,
  output logic ext_rise_o,
  output logic tick_o
);

  logic [SYNC_N-1:0] sync_q;
  logic              lvl_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      lvl_d_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_N-2:0], ext_i};
      lvl_d_q <= sync_q[SYNC_N-1];
    end
  end

  assign ext_lvl_o  = sync_q[SYNC_N-1];
  assign ext_rise_o = sync_q[SYNC_N-1] & ~lvl_d_q;

  // Internal time base: one tick every 2**DIV_W clocks.
  generate
    if (DIV_W == 0) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
      end
      assign tick_o = &div_q;

      assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

  assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise_o |=> !ext_rise_o);

endmodule

// File: rtl/dpt_channel.sv
module dpt_channel import dpt_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic [PRE_W-1:0] init_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             eoc_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             act_q;
  logic             adv;
  logic             pre_wrap;

  assign adv      = tick_i & en_i & act_q & ~load_i;
  assign pre_wrap = adv & (pre_q == PRE_ONE);
  assign eoc_o    = pre_wrap & (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= init_cnt_i;
      pre_q <= init_pre_i;
      act_q <= 1'b1;
    end else if (pre_wrap) begin
      pre_q <= init_pre_i;
      if (eoc_o && reload_i) begin
        cnt_q <= init_cnt_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (eoc_o) act_q <= 1'b0;
      end
    end else if (adv) begin
      pre_q <= pre_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;

  assert_presc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pre_q != PRE_ONE) |=> $stable(cnt_q));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_o && reload_i) |=> (cnt_q == $past(init_cnt_i)) && act_q);

  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_o && !reload_i) |=> (!act_q && cnt_q == '0));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> ($stable(cnt_q) && $stable(pre_q)));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (act_q && span(32'(cnt_q), CNT_W) == span(32'($past(init_cnt_i)), CNT_W)));

endmodule

// File: rtl/dpt_out_sel.sv
module dpt_out_sel import dpt_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  out_sel_e sel_i,
  input  logic     eoc0_i,
  input  logic     eoc1_i,
  input  logic     tick_i,
  output logic     tout_o
);

  logic tog_q;
  logic evt;

  always_comb begin
    case (sel_i)
      OUT_T0:   evt = eoc0_i;
      OUT_T1:   evt = eoc1_i;
      OUT_TICK: evt = tick_i;
      default:  evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tog_q <= 1'b0;
    else if (sel_i == OUT_OFF) tog_q <= 1'b0;
    else if (evt)              tog_q <= ~tog_q;
  end

  assign tout_o = tog_q;

  assert_tout_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == OUT_OFF) |=> !tout_o);

endmodule

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer import dpt_pkg::*; #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 6,
  parameter int DIV_W  = 2,
  parameter int SYNC_N = 2,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_in,
  output logic [CNT_W-1:0]  count0,
  output logic [CNT_W-1:0]  count1,
  output logic              irq0,
  output logic              irq1,
  output logic              tout
);

  localparam int RL_BIT  = PRE_W;
  localparam int SRC_BIT = PRE_W + 1;

  logic [CNT_W-1:0] init0_q, init1_q;
  logic [PRE_W-1:0] pre0_q, pre1_q;
  logic             rl0_q, rl1_q, src_int_q, chain_q, en0_q, en1_q;
  ext_mode_e        mode_q;
  out_sel_e         osel_q;

  logic wr_ctrl, load0, load1, trig_mode, trig_load;
  logic tick_int, ext_lvl, ext_rise;
  logic tick1, eoc0, eoc1, act0, act1;
  logic irq0_q, irq1_q;

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init0_q   <= '0;
      init1_q   <= '0;
      pre0_q    <= '0;
      pre1_q    <= '0;
      rl0_q     <= 1'b0;
      rl1_q     <= 1'b0;
      src_int_q <= 1'b0;
      chain_q   <= 1'b0;
      en0_q     <= 1'b0;
      en1_q     <= 1'b0;
      mode_q    <= EXT_CLOCK;
      osel_q    <= OUT_OFF;
    end else if (wr_en) begin
      case (wr_addr)
        REG_T0_INIT: init0_q <= wr_data[CNT_W-1:0];
        REG_T1_INIT: init1_q <= wr_data[CNT_W-1:0];
        REG_T0_PRE: begin
          pre0_q <= wr_data[PRE_W-1:0];
          rl0_q  <= wr_data[RL_BIT];
        end
        REG_T1_PRE: begin
          pre1_q    <= wr_data[PRE_W-1:0];
          rl1_q     <= wr_data[RL_BIT];
          src_int_q <= wr_data[SRC_BIT];
        end
        REG_CTRL: begin
          en0_q  <= wr_data[1];
          en1_q  <= wr_data[3];
          mode_q <= ext_mode_e'(wr_data[5:4]);
          osel_q <= out_sel_e'(wr_data[7:6]);
        end
        REG_CHAIN: chain_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  dpt_input_cond #(.SYNC_N(SYNC_N), .DIV_W(DIV_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_in),
    .ext_lvl_o(ext_lvl), .ext_rise_o(ext_rise), .tick_o(tick_int)
  );

  // Timer 1 source selection; chaining overrides everything else.
  always_comb begin
    trig_mode = 1'b0;
    if (chain_q)        tick1 = eoc0;
    else if (src_int_q) tick1 = tick_int;
    else begin
      case (mode_q)
        EXT_CLOCK: tick1 = ext_rise;
        EXT_GATE:  tick1 = tick_int & ext_lvl;
        default: begin
          tick1     = tick_int;
          trig_mode = 1'b1;
        end
      endcase
    end
  end

  assign trig_load = trig_mode & ext_rise & ((mode_q == EXT_TRIG_RE) | ~act1);
  assign load0     = wr_ctrl & wr_data[0];
  assign load1     = (wr_ctrl & wr_data[2]) | trig_load;

  dpt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_t0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_int), .load_i(load0), .en_i(en0_q),
    .reload_i(rl0_q), .init_cnt_i(init0_q), .init_pre_i(pre0_q),
    .cnt_o(count0), .active_o(act0), .eoc_o(eoc0)
  );

  dpt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick1), .load_i(load1), .en_i(en1_q),
    .reload_i(rl1_q), .init_cnt_i(init1_q), .init_pre_i(pre1_q),
    .cnt_o(count1), .active_o(act1), .eoc_o(eoc1)
  );

  dpt_out_sel u_out (
    .clk(clk), .rst_n(rst_n), .sel_i(osel_q), .eoc0_i(eoc0), .eoc1_i(eoc1),
    .tick_i(tick_int), .tout_o(tout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= eoc0;
      irq1_q <= eoc1;
    end
  end

  assign irq0 = irq0_q;
  assign irq1 = irq1_q;

  assert_irq0_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |=> !irq0);
  assert_irq1_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |=> !irq1);
  assert_idle0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !act0 |=> !irq0);
  assert_idle1_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !act1 |=> !irq1);
  assert_once_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode && mode_q == EXT_TRIG_ONCE && act1 && ext_rise && !wr_ctrl && en1_q && !tick1)
      |=> $stable(count1));

endmodule

// File: tb/test_dual_prescaled_timer.sv
module test_dual_prescaled_timer;
  import dpt_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_in = 1'b0;
  logic [7:0] count0, count1;
  logic       irq0, irq1, tout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cyc = 0;
  int n0 = 0, n1 = 0, ntg = 0;
  int t0_last = 0, t0_prev = 0, t1_last = 0, t1_prev = 0, tg_last = 0, tg_prev = 0;
  logic tout_d = 1'b0, irq0_d = 1'b0, irq1_d = 1'b0;
  int wide = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_prescaled_timer i_dual_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_in(ext_in), .count0(count0), .count1(count1), .irq0(irq0), .irq1(irq1), .tout(tout)
  );

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (irq0) begin n0++; t0_prev = t0_last; t0_last = cyc; end
    if (irq1) begin n1++; t1_prev = t1_last; t1_last = cyc; end
    if (tout !== tout_d) begin ntg++; tg_prev = tg_last; tg_last = cyc; end
    if ((irq0 && irq0_d) || (irq1 && irq1_d)) wide++;
    tout_d = tout; irq0_d = irq0; irq1_d = irq1;
  end

  function automatic int period_of(input int n, input int p);
    return span(n, 8) * span(p, 6) * 4;
  endfunction

  function automatic logic [7:0] ctl(input bit l0, input bit e0, input bit l1, input bit e1,
                                     input logic [1:0] m, input logic [1:0] o);
    return {o, m, e1, l1, e0, l0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  // which: 0 irq0, 1 irq1, 2 tout toggle
  task automatic wait_events(input int which, input int k, input int limit);
    int start;
    int got;
    start = (which == 0) ? n0 : (which == 1) ? n1 : ntg;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #1;
      got = (which == 0) ? n0 : (which == 1) ? n1 : ntg;
      if (got - start >= k) break;
    end
  endtask

  task automatic ext_pulse(input int hi, input int lo);
    @(negedge clk); ext_in = 1'b1;
    repeat (hi) @(negedge clk);
    ext_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    int n, p, exp, c, snap, te, base;
    void'($urandom(32'd31337));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R12 reset state
    chk(count0 == 0 && count1 == 0, "R12 reset counts", int'(count0) + int'(count1), 0);
    chk(!irq0 && !irq1 && !tout, "R12 reset outputs", int'({irq0, irq1, tout}), 0);

    // R1/R3 random periods on timer 0
    for (int i = 0; i < 6; i++) begin
      n = $urandom % 6 + 1; p = $urandom % 4 + 1;
      wr(REG_T0_INIT, 8'(n));
      wr(REG_T0_PRE, 8'(8'h40 | p));
      wr(REG_CTRL, ctl(1, 1, 0, 0, 2'b00, 2'b00));
      wait_events(0, 2, 2000);
      chk(t0_last - t0_prev == period_of(n, p), "R1 R3 timer0 period", t0_last - t0_prev, period_of(n, p));
    end

    // R1/R3 random periods on timer 1 from the internal time base
    for (int i = 0; i < 4; i++) begin
      n = $urandom % 6 + 1; p = $urandom % 4 + 1;
      wr(REG_T1_INIT, 8'(n));
      wr(REG_T1_PRE, 8'(8'hC0 | p));
      wr(REG_CTRL, ctl(0, 0, 1, 1, 2'b00, 2'b00));
      wait_events(1, 2, 2000);
      chk(t1_last - t1_prev == period_of(n, p), "R1 R3 timer1 period", t1_last - t1_prev, period_of(n, p));
    end

    // R2 count of zero means 256
    wr(REG_T0_INIT, 8'd0); wr(REG_T0_PRE, 8'h41);
    wr(REG_CTRL, ctl(1, 1, 0, 0, 2'b00, 2'b00));
    wait_events(0, 2, 3000);
    chk(t0_last - t0_prev == 1024, "R2 zero count", t0_last - t0_prev, 1024);

    // R1 prescaler of zero means 64
    wr(REG_T0_INIT, 8'd1); wr(REG_T0_PRE, 8'h40);
    wr(REG_CTRL, ctl(1, 1, 0, 0, 2'b00, 2'b00));
    wait_events(0, 2, 1000);
    chk(t0_last - t0_prev == 256, "R1 zero prescale", t0_last - t0_prev, 256);

    // R4 single pass
    wr(REG_T0_INIT, 8'd3); wr(REG_T0_PRE, 8'h02);
    base = n0;
    wr(REG_CTRL, ctl(1, 1, 0, 0, 2'b00, 2'b00));
    idle(160);
    chk(n0 - base == 1, "R4 single request", n0 - base, 1);
    chk(count0 == 0, "R4 stopped count", count0, 0);

    // R5 enable freezes and continues
    wr(REG_T0_INIT, 8'd200); wr(REG_T0_PRE, 8'h41);
    wr(REG_CTRL, ctl(1, 1, 0, 0, 2'b00, 2'b00));
    idle(40);
    wr(REG_CTRL, ctl(0, 0, 0, 0, 2'b00, 2'b00));
    idle(3); snap = count0;
    idle(30);
    chk(count0 == snap, "R5 frozen count", count0, snap);
    chk(snap < 200 && snap > 185, "R5 counted before freeze", snap, 190);
    wr(REG_CTRL, ctl(0, 1, 0, 0, 2'b00, 2'b00));
    idle(20);
    chk(count0 < snap && count0 >= snap - 6, "R5 continues", count0, snap - 5);
    wr(REG_CTRL, ctl(0, 0, 0, 0, 2'b00, 2'b00));

    // R6 external clock edges
    wr(REG_T1_INIT, 8'd3); wr(REG_T1_PRE, 8'h42);
    wr(REG_CTRL, ctl(0, 0, 1, 1, 2'b00, 2'b00));
    base = n1;
    for (int i = 0; i < 5; i++) ext_pulse(3, 3);
    idle(10);
    chk(n1 == base, "R6 no request before sixth edge", n1 - base, 0);
    ext_pulse(3, 3);
    idle(10);
    chk(n1 - base == 1, "R6 request on sixth edge", n1 - base, 1);

    // R7 gate
    wr(REG_T1_INIT, 8'd250); wr(REG_T1_PRE, 8'h41);
    wr(REG_CTRL, ctl(0, 0, 1, 1, 2'b01, 2'b00));
    idle(40);
    chk(count1 == 250, "R7 gate low holds", count1, 250);
    ext_in = 1'b1; idle(40); ext_in = 1'b0; idle(8);
    c = count1;
    chk(c < 250 && c >= 238, "R7 gate high counts", c, 240);
    idle(30);
    chk(count1 == c, "R7 gate low again holds", count1, c);

    // Idle timer 1: short single pass from the internal base
    wr(REG_T1_INIT, 8'd1); wr(REG_T1_PRE, 8'h81);
    wr(REG_CTRL, ctl(0, 0, 1, 1, 2'b00, 2'b00));
    idle(20);

    // R8 non-retriggerable trigger
    wr(REG_T1_INIT, 8'd5); wr(REG_T1_PRE, 8'h02);
    wr(REG_CTRL, ctl(0, 0, 0, 1, 2'b10, 2'b00));
    base = n1;
    idle(20);
    chk(n1 == base, "R8 no count before trigger", n1 - base, 0);
    @(negedge clk); ext_in = 1'b1; te = cyc;
    repeat (4) @(negedge clk); ext_in = 1'b0;
    repeat (15) @(negedge clk); ext_in = 1'b1;
    repeat (4) @(negedge clk); ext_in = 1'b0;
    idle(100);
    chk(n1 - base == 1, "R8 one request", n1 - base, 1);
    chk(t1_last - te >= 36 && t1_last - te <= 50, "R8 second edge ignored", t1_last - te, 43);

    // R9 retriggerable trigger
    wr(REG_CTRL, ctl(0, 0, 0, 1, 2'b11, 2'b00));
    base = n1;
    @(negedge clk); ext_in = 1'b1; te = cyc;
    repeat (4) @(negedge clk); ext_in = 1'b0;
    repeat (16) @(negedge clk); ext_in = 1'b1;
    repeat (4) @(negedge clk); ext_in = 1'b0;
    idle(100);
    chk(n1 - base == 1, "R9 one request", n1 - base, 1);
    chk(t1_last - te >= 56 && t1_last - te <= 70, "R9 second edge reloads", t1_last - te, 63);

    // R10 chaining
    wr(REG_T0_INIT, 8'd2); wr(REG_T0_PRE, 8'h41);
    wr(REG_T1_INIT, 8'd3); wr(REG_T1_PRE, 8'h41);
    wr(REG_CHAIN, 8'h01);
    wr(REG_CTRL, ctl(1, 1, 1, 1, 2'b00, 2'b00));
    wait_events(1, 2, 500);
    chk(t1_last - t1_prev == 24, "R10 chained period", t1_last - t1_prev, 24);

    // R11 output select
    wr(REG_CTRL, ctl(0, 1, 0, 1, 2'b00, 2'b01));
    wait_events(2, 3, 300);
    chk(tg_last - tg_prev == 8, "R11 tout from timer0", tg_last - tg_prev, 8);
    wr(REG_CTRL, ctl(0, 1, 0, 1, 2'b00, 2'b10));
    wait_events(2, 3, 500);
    chk(tg_last - tg_prev == 24, "R11 tout from timer1", tg_last - tg_prev, 24);
    wr(REG_CTRL, ctl(0, 1, 0, 1, 2'b00, 2'b11));
    wait_events(2, 3, 100);
    chk(tg_last - tg_prev == 4, "R11 tout from time base", tg_last - tg_prev, 4);
    wr(REG_CTRL, ctl(0, 1, 0, 1, 2'b00, 2'b00));
    idle(3); base = ntg;
    idle(40);
    chk(!tout && ntg == base, "R11 tout off", ntg - base, 0);

    // R12 pulse width over the whole run
    chk(wide == 0, "R12 one-cycle requests", wide, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R12 actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule